// File: doc/BRIEF.md
# NOR flash command sequence decoder

This block sits between a host bus and the word array of an emulated parallel NOR flash. The host writes a word address and a data value. The decoder tracks the classic two-write unlock handshake, then a command byte, and from these it starts one of several actions. A program operation clears bits only: the new data is ANDed into the stored word. An erase fills either one sector or the whole array with all-ones words. Other commands switch the read mode to identification, query-table reads or status polling.

A built-in storage engine carries out each program or erase. A program is a read-modify-write that takes two cycles. An erase writes one word per cycle across its range. While the engine runs, the block reports busy and the read-path mode shows status. The write channel and the read-request channel use valid/ready. Both ready outputs are held high, so there is never back-pressure: every write the host presents with valid high is consumed in that cycle. A write consumed while the engine is busy is dropped. Each read request returns the stored word exactly one cycle later. The mode output tells the external read path how to interpret the reads.

Top module: `nfc_cmd_seq`

## Requirements
- R1: After reset, mode is 0 (array read), busy is low, and cmd_ready and rd_ready are high.
- R2: A command is accepted only after data 0xAA at word offset UNLOCK_A followed by data 0x55 at word offset UNLOCK_B. If either write has the wrong address or the wrong data, the decoder stays in or returns to array read and the command that follows does nothing.
- R3: Program is entered with data 0xA0 at UNLOCK_A after the unlock pair. The next write stores old AND data at its word address, so stored bits only go from 1 to 0.
- R4: From the moment 0xA0 is accepted until the program finishes, mode is 3 (status). A data value of 0xF0 written in that window is used as program data and does not reset the decoder. Outside bypass, the decoder then returns to mode 0.
- R5: Data 0x90 after the unlock pair gives mode 1 (autoselect). Data 0xF0 in any state other than program data returns the decoder to mode 0 and clears bypass.
- R6: Data 0x98 at word offset 0x55 enters mode 2 (query) from array read and from autoselect. Any write accepted in mode 2 returns the decoder to mode 0.
- R7: The sequence unlock, 0x80, unlock, then 0x30 at any address fills every word of that address's sector with all ones and leaves other sectors unchanged.
- R8: The sequence unlock, 0x80, unlock, then 0x10 at UNLOCK_A fills the whole array with all ones. Data 0x10 at any other offset aborts the sequence with no erase.
- R9: While busy is high, mode is 3 and every write (0xF0 included) is ignored.
- R10: Data 0x20 after the unlock pair enters bypass. In bypass, command writes need no unlock pair and no particular address, and a finished program or erase returns to the command step. The writes 0x90 then 0x00 leave bypass.
- R11: The word offset is the byte address shifted right by log2(BUS_BYTES), taken modulo SECTOR_WORDS for every command-address comparison.
- R12: A read request accepted in one cycle raises rd_resp_valid in the next cycle, carrying the stored word. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host write present |
| cmd_ready | output | 1 | Always high; the write is consumed |
| cmd_addr | input | ADDR_W | Byte address of the write |
| cmd_data | input | 8*BUS_BYTES | Write data; the low byte is the command |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Always high |
| rd_addr | input | ADDR_W | Byte address to read |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_resp_data | output | 8*BUS_BYTES | Stored word |
| mode | output | 2 | 0 array, 1 autoselect, 2 query, 3 status |
| busy | output | 1 | Program or erase in progress |

## Verification
A wrong decoder state shows on mode as soon as the next cycle after the write that caused it, because mode is decoded straight from the state register. A wrong state that maps to the same mode only shows later, through storage. Examples are a lost unlock step, a bypass flag that stays set, or a command step reached without an unlock pair. A write that should have programmed nothing then changes a word, or a program that should have taken effect leaves the word at all ones. That difference appears in the read response one cycle after the word is read back. An erase with the wrong range shows as a neighbouring sector's word turned to all ones. It also shows as busy staying high for a number of cycles that does not match the range.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_QUERY   = 2'd2,
    MODE_STATUS  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_CMD, S_PROG, S_AUTO,
    S_EUNL0, S_EUNL1, S_ECMD, S_QUERY, S_BUSY
  } dec_state_e;

  localparam logic [7:0] C_UNL0  = 8'hAA;
  localparam logic [7:0] C_UNL1  = 8'h55;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_AUTO  = 8'h90;
  localparam logic [7:0] C_ESET  = 8'h80;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_QUERY = 8'h98;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BYPX  = 8'h00;
  localparam int         QUERY_OFF = 'h55;
endpackage

// File: rtl/nfc_word_ram.sv
module nfc_word_ram #(
  parameter int AW  = 10,
  parameter int DW  = 8,
  parameter int NRD = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) rdata[g] <= mem[raddr[g]];
  end
endmodule

// File: rtl/nfc_store_eng.sv
module nfc_store_eng
  import nfc_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int OFF_W   = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  op_e                op,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DW-1:0]      data,
  output logic               done,
  output logic               we,
  output logic               fill,
  output logic [WORD_AW-1:0] waddr,
  output logic [DW-1:0]      wdata,
  output logic [WORD_AW-1:0] raddr,
  input  logic [DW-1:0]      rdata
);
  localparam int SEC_W = WORD_AW - OFF_W;

  typedef enum logic [1:0] {E_IDLE, E_PRD, E_PWR, E_FILL} eng_e;

  eng_e               st;
  logic [WORD_AW-1:0] addr_q, ptr, last;
  logic [DW-1:0]      data_q;
  logic [SEC_W-1:0]   sec;

  assign sec = addr[WORD_AW-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      addr_q <= '0;
      data_q <= '0;
      ptr    <= '0;
      last   <= '0;
    end else begin
      unique case (st)
        E_IDLE: if (start) begin
          addr_q <= addr;
          data_q <= data;
          if (op == OP_PROG) begin
            st <= E_PRD;
          end else begin
            st <= E_FILL;
            if (op == OP_CHIP) begin
              ptr  <= '0;
              last <= '1;
            end else begin
              ptr  <= {sec, {OFF_W{1'b0}}};
              last <= {sec, {OFF_W{1'b1}}};
            end
          end
        end
        E_PRD:  st <= E_PWR;
        E_PWR:  st <= E_IDLE;
        E_FILL: begin
          ptr <= ptr + 1'b1;
          if (ptr == last) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    fill  = (st == E_FILL);
    we    = (st == E_PWR) || fill;
    waddr = fill ? ptr : addr_q;
    wdata = fill ? {DW{1'b1}} : (rdata & data_q);
    raddr = addr_q;
    done  = (st == E_PWR) || (fill && (ptr == last));
  end
endmodule

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
  import nfc_pkg::*;
#(
  parameter int WORD_AW  = 10,
  parameter int OFF_W    = 8,
  parameter int DW       = 8,
  parameter int UNLOCK_A = 'h55,
  parameter int UNLOCK_B = 'hAA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [DW-1:0]      wr_data,
  input  logic               eng_done,
  output logic               start,
  output op_e                start_op,
  output logic [WORD_AW-1:0] start_addr,
  output logic [DW-1:0]      start_data,
  output logic               busy,
  output mode_e              mode
);
  localparam logic [OFF_W-1:0] UA = OFF_W'(UNLOCK_A);
  localparam logic [OFF_W-1:0] UB = OFF_W'(UNLOCK_B);
  localparam logic [OFF_W-1:0] QO = OFF_W'(QUERY_OFF);

  dec_state_e       st;
  logic             byp;
  logic [7:0]       cmd;
  logic [OFF_W-1:0] off;

  assign cmd = wr_data[7:0];
  assign off = wr_word[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_READ;
      byp        <= 1'b0;
      start      <= 1'b0;
      start_op   <= OP_PROG;
      start_addr <= '0;
      start_data <= '0;
    end else begin
      start <= 1'b0;
      if (st == S_BUSY) begin
        if (eng_done) st <= byp ? S_CMD : S_READ;
      end else if (wr_fire) begin
        start_addr <= wr_word;
        start_data <= wr_data;
        if (cmd == C_RESET && st != S_PROG) begin
          st  <= S_READ;
          byp <= 1'b0;
        end else begin
          st  <= S_READ;
          byp <= 1'b0;
          unique case (st)
            S_READ: begin
              if (off == QO && cmd == C_QUERY)    st <= S_QUERY;
              else if (off == UA && cmd == C_UNL0) st <= S_UNL1;
            end
            S_UNL1: if (off == UB && cmd == C_UNL1) st <= S_CMD;
            S_CMD: begin
              if (byp || off == UA) begin
                byp <= byp;
                unique case (cmd)
                  C_BYP:  begin byp <= 1'b1; st <= S_CMD; end
                  C_PROG: st <= S_PROG;
                  C_AUTO: st <= S_AUTO;
                  C_ESET: st <= S_EUNL0;
                  default: byp <= 1'b0;
                endcase
              end
            end
            S_PROG: begin
              byp      <= byp;
              st       <= S_BUSY;
              start    <= 1'b1;
              start_op <= OP_PROG;
            end
            S_AUTO: begin
              if (off == QO && cmd == C_QUERY) st <= S_QUERY;
            end
            S_EUNL0: if (off == UA && cmd == C_UNL0) begin
              byp <= byp; st <= S_EUNL1;
            end
            S_EUNL1: if (off == UB && cmd == C_UNL1) begin
              byp <= byp; st <= S_ECMD;
            end
            S_ECMD: begin
              if (cmd == C_CHIP && off == UA) begin
                byp <= byp; st <= S_BUSY; start <= 1'b1; start_op <= OP_CHIP;
              end else if (cmd == C_SECT) begin
                byp <= byp; st <= S_BUSY; start <= 1'b1; start_op <= OP_SECT;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    busy = (st == S_BUSY);
    unique case (st)
      S_AUTO:         mode = MODE_AUTOSEL;
      S_QUERY:        mode = MODE_QUERY;
      S_PROG, S_BUSY: mode = MODE_STATUS;
      default:        mode = MODE_ARRAY;
    endcase
  end
endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
  import nfc_pkg::*;
#(
  parameter int BUS_BYTES    = 1,
  parameter int SECTOR_WORDS = 256,
  parameter int SECTORS      = 4,
  parameter int UNLOCK_A     = 'h55,
  parameter int UNLOCK_B     = 'hAA,
  localparam int BYTE_SH     = $clog2(BUS_BYTES),
  localparam int OFF_W       = $clog2(SECTOR_WORDS),
  localparam int WORD_AW     = $clog2(SECTOR_WORDS * SECTORS),
  localparam int ADDR_W      = WORD_AW + BYTE_SH,
  localparam int DW          = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DW-1:0]     rd_resp_data,
  output logic [1:0]        mode,
  output logic              busy
);
  logic               start, eng_done, ram_we, eng_fill;
  op_e                start_op;
  mode_e              mode_int;
  logic [WORD_AW-1:0] start_addr, ram_waddr, eng_raddr, cmd_word, rd_word;
  logic [DW-1:0]      start_data, ram_wdata, eng_old;
  logic [1:0][WORD_AW-1:0] ram_raddr;
  logic [1:0][DW-1:0]      ram_rdata;

  assign cmd_ready = 1'b1;
  assign rd_ready  = 1'b1;
  assign cmd_word  = WORD_AW'(cmd_addr >> BYTE_SH);
  assign rd_word   = WORD_AW'(rd_addr >> BYTE_SH);
  assign mode      = mode_int;

  nfc_cmd_fsm #(
    .WORD_AW(WORD_AW), .OFF_W(OFF_W), .DW(DW),
    .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(cmd_valid && cmd_ready), .wr_word(cmd_word), .wr_data(cmd_data),
    .eng_done(eng_done),
    .start(start), .start_op(start_op), .start_addr(start_addr),
    .start_data(start_data), .busy(busy), .mode(mode_int)
  );

  nfc_store_eng #(.WORD_AW(WORD_AW), .OFF_W(OFF_W), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start), .op(start_op), .addr(start_addr), .data(start_data),
    .done(eng_done), .we(ram_we), .fill(eng_fill),
    .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(eng_raddr), .rdata(eng_old)
  );

  assign ram_raddr[0] = eng_raddr;
  assign ram_raddr[1] = rd_word;
  assign eng_old      = ram_rdata[0];
  assign rd_resp_data = ram_rdata[1];

  nfc_word_ram #(.AW(WORD_AW), .DW(DW), .NRD(2)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_resp_valid <= 1'b0;
    else        rd_resp_valid <= rd_valid && rd_ready;
  end
endmodule

// File: rtl/nfc_cmd_chk.sv
module nfc_cmd_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          rd_valid,
  input logic          rd_resp_valid,
  input logic [1:0]    mode,
  input logic          busy,
  input logic          we,
  input logic          fill,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] old
);
  // R3
  prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !fill) |-> ((wdata & ~old) == '0));

  // R7
  fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && fill) |-> (&wdata));

  // R6
  query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && cmd_valid) |=> (mode == 2'd0));

  // R9
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode == 2'd3));

  // R9
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy);

  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);

  // R12
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_resp_valid);
endmodule

bind nfc_cmd_seq nfc_cmd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rd_valid(rd_valid),
  .rd_resp_valid(rd_resp_valid), .mode(mode), .busy(busy),
  .we(ram_we), .fill(eng_fill), .wdata(ram_wdata), .old(eng_old)
);

// File: tb/sim_nfc_cmd_seq.sv
`timescale 1ns/1ps
module sim_nfc_cmd_seq;
  localparam int AW = 10;
  localparam int UA = 'h055;
  localparam int UB = 'h0AA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          cmd_ready, rd_ready, rd_resp_valid, busy;
  logic [7:0]    rd_resp_data;
  logic [1:0]    mode;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 1'b0;

  logic [7:0] q_exp[$];
  int         q_addr[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  nfc_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
    .rd_resp_data(rd_resp_data), .mode(mode), .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read responses arrive
  always @(negedge clk) begin
    if (rd_resp_valid) begin
      if (q_exp.size() == 0) begin
        check("R12 unexpected response", 1, 0);
      end else begin
        automatic logic [7:0] e = q_exp.pop_front();
        automatic int a = q_addr.pop_front();
        automatic string t = q_tag.pop_front();
        check($sformatf("%s @%0h", t, a), rd_resp_data, e);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = AW'(a); cmd_data = 8'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_exp(int a, int e, string tag);
    @(negedge clk);
    q_exp.push_back(8'(e)); q_addr.push_back(a); q_tag.push_back(tag);
    rd_valid = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(UA, 'hAA); wr(UB, 'h55);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 mode", mode, 0);
    check("R1 busy", busy, 0);
    check("R1 ready", {cmd_ready, rd_ready}, 2'b11);

    // R8 chip erase, R9 ignored writes while busy
    unlock(); wr(UA, 'h80); unlock(); wr(UA, 'h10);
    check("R8 busy after chip erase", busy, 1);
    check("R9 mode while busy", mode, 3);
    wr(0, 'hF0); unlock(); wr(UA, 'hA0);
    check("R9 still busy after writes", busy, 1);
    wait_idle();
    check("R9 mode after erase", mode, 0);
    wr(5, 'h00);
    rd_exp(5, 'hFF, "R9 dropped program");
    rd_exp(0, 'hFF, "R8 erased");
    rd_exp('h12C, 'hFF, "R8 erased");
    rd_exp('h3FF, 'hFF, "R8 erased");

    // R3, R4 program with AND semantics
    unlock(); wr(UA, 'hA0);
    check("R4 status mode", mode, 3);
    wr(10, 'h3C);
    wait_idle();
    check("R4 back to array", mode, 0);
    rd_exp(10, 'h3C, "R3 program");
    unlock(); wr(UA, 'hA0); wr(10, 'hF0);
    wait_idle();
    rd_exp(10, 'h30, "R4 F0 as data, R3 AND");

    // R2 broken unlock
    wr(UA + 1, 'hAA); wr(UB, 'h55); wr(UA, 'hA0); wr(20, 'h00);
    rd_exp(20, 'hFF, "R2 bad address");
    wr(UA, 'hAA); wr(UB, 'h54); wr(UA, 'hA0); wr(21, 'h00);
    rd_exp(21, 'hFF, "R2 bad data");

    // R11 offsets modulo sector size
    wr('h255, 'hAA); wr('h2AA, 'h55); wr('h355, 'hA0); wr('h230, 'h0F);
    wait_idle();
    rd_exp('h230, 'h0F, "R11 other-sector unlock");

    // R5 autoselect, R6 query
    unlock(); wr(UA, 'h90);
    check("R5 autoselect", mode, 1);
    wr(0, 'hF0);
    check("R5 F0 reset", mode, 0);
    unlock(); wr(UA, 'h90); wr('h55, 'h98);
    check("R6 query from autoselect", mode, 2);
    wr(0, 'h00);
    check("R6 query exit", mode, 0);
    wr('h155, 'h98);
    check("R6 query from idle", mode, 2);
    wr(0, 'hF0);
    check("R6 query exit by F0", mode, 0);

    // R7 sector erase
    unlock(); wr(UA, 'hA0); wr('h12C, 'h5A);
    wait_idle();
    rd_exp('h12C, 'h5A, "R3 program sector 1");
    unlock(); wr(UA, 'h80); unlock(); wr('h1F0, 'h30);
    check("R7 busy", busy, 1);
    wait_idle();
    rd_exp('h12C, 'hFF, "R7 sector erased");
    rd_exp(10, 'h30, "R7 sector 0 kept");
    rd_exp('h230, 'h0F, "R7 sector 2 kept");

    // R8 abort
    unlock(); wr(UA, 'h80); unlock(); wr(UA + 1, 'h10);
    check("R8 abort no busy", busy, 0);
    rd_exp(10, 'h30, "R8 abort kept data");

    // R10 bypass
    unlock(); wr(UA, 'h20);
    wr('h3FF, 'hA0); wr(40, 'h01);
    wait_idle();
    check("R10 bypass mode", mode, 0);
    rd_exp(40, 'h01, "R10 bypass program");
    wr('h123, 'hA0); wr(41, 'h80);
    wait_idle();
    rd_exp(41, 'h80, "R10 bypass repeat");
    wr(0, 'h90);
    check("R10 bypass autoselect", mode, 1);
    wr(0, 'h00);
    check("R10 bypass exit", mode, 0);
    wr(UA, 'hA0); wr(42, 'h00);
    wait_idle();
    rd_exp(42, 'hFF, "R10 no program after exit");

    repeat (4) @(negedge clk);
    check("R12 scoreboard drained", q_exp.size(), 0);
    finish_run();
  end
endmodule